// File: doc/BRIEF.md
# Asynchronous SRAM-Style Memory Sequencer

This block sits between a synchronous host port and an external byte-wide, non-volatile memory that has an asynchronous, SRAM-compatible pin interface. The host hands over one byte-wide request at a time: a 17-bit address, a write flag and, for writes, a data byte. The request is taken on a clock edge where both `req_valid` and `req_ready` are high. The block then drives the memory's active-low chip-select, write-strobe and output-enable pins, plus the 8-bit data bus, in a fixed sequence. For reads, it returns the sampled byte with a one-cycle `rsp_valid` pulse.

Every analog timing limit of the memory is held as a nanosecond parameter. Each one becomes a wait count of ceil(ns / `CLK_PERIOD_NS`) cycles, never less than one. The block also owns the supply startup hold. After the digital `pwr_good` input rises, all strobes stay inactive for `STARTUP_NS` before the first access. If `pwr_good` falls at any point, the access in flight is dropped and the full hold starts again.

The data bus is split into separate output, output-enable and input signals; the pad is outside this block.

Top module: `amem_ctrl`

## Requirements
- R1: While reset is active, and after it with `pwr_good` low, `mem_ce_n`, `mem_we_n` and `mem_oe_n` are 1, `mem_dq_oe` is 0, and `req_ready` and `rsp_valid` are 0.
- R2: `req_ready` first reads 1 exactly HOLD+1 rising edges after `pwr_good` is first sampled high, where HOLD = max(1, ceil(`STARTUP_NS`/`CLK_PERIOD_NS`)). During that time, a held `req_valid` causes no strobe activity.
- R3: A write pulls `mem_ce_n` and `mem_we_n` low on the accepting edge. `mem_we_n` stays low for exactly WP cycles, where WP = max(1, ceil(max(15, 18, 10) ns / period)). During the pulse, `mem_addr` carries the request address and `mem_dq_out` carries the write byte.
- R4: After a write pulse, `mem_ce_n` and `mem_we_n` are high while `mem_addr` and `mem_dq_out` keep their values. `req_ready` returns after WR cycles, where WR = max(ceil(12 ns), ceil(2 ns), ceil(35 ns) − WP, 1).
- R5: `mem_oe_n` is 1 for the whole of a write. `mem_dq_oe` is 1 only during a write pulse and its recovery, and never while `mem_oe_n` is 0.
- R6: A read pulls `mem_ce_n` low with `mem_oe_n` still 1 and `mem_dq_oe` 0. One cycle later `mem_oe_n` falls and stays low for RW cycles, where RW = max(1, ceil(35 ns) − 1, ceil(15 ns)).
- R7: The read byte is sampled from `mem_dq_in` on the edge that ends the last `mem_oe_n`-low cycle. `rsp_valid` is 1 for exactly the following cycle, and `rsp_rdata` holds the byte after that.
- R8: After a read, `mem_ce_n` stays high for GP = max(1, ceil(2 ns)) cycles before `req_ready` returns. Consecutive falling edges of `mem_ce_n` are at least ceil(35 ns) cycles apart.
- R9: `req_ready` is 1 only when no access is in progress and `pwr_good` is high. A request presented while it is 0 has no effect.
- R10: The edge that first samples `pwr_good` low drives all three strobes high and `req_ready` low. An interrupted read produces no `rsp_valid`, and the full R2 hold repeats after `pwr_good` returns.
- R11: `mem_addr` is unchanged from the accepting edge until `req_ready` returns, even if `req_addr` changes meanwhile.
- R12: A read returns the byte most recently written to the same address, for addresses including 0x00000 and 0x1FFFF and data 0x00, 0xFF and mixed patterns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good | input | 1 | Supply-in-range flag, synchronous to clk |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-cycle pulse: read byte available |
| rsp_rdata | output | 8 | Last read byte |
| mem_addr | output | 17 | Address pins of the memory |
| mem_dq_out | output | 8 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Drive enable for the data pins |
| mem_dq_in | input | 8 | Data seen on the memory pins |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |

## Verification
A table of writes and reads is replayed against a byte-array memory model. It reaches the lowest and highest address and uses all-zero, all-one and mixed bytes, so that a stuck or swapped address or data bit shows up as a wrong read-back. The same walk times every strobe phase in cycles, which separates a wrong wait count from a wrong phase order. Directed cases present a request during the startup hold and change `req_addr` while an access is busy; both must have no effect. A supply drop in the middle of a read must abort the access cleanly and restart the hold with its full length.

// File: rtl/amem_pkg.sv
package amem_pkg;

  typedef enum logic [2:0] {
    ST_HOLD   = 3'd0,
    ST_IDLE   = 3'd1,
    ST_RADDR  = 3'd2,
    ST_RWAIT  = 3'd3,
    ST_RGAP   = 3'd4,
    ST_WPULSE = 3'd5,
    ST_WREC   = 3'd6
  } amem_state_e;

  // ceil(ns / period) with a floor of one cycle
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned per);
    int unsigned c;
    c = (ns + per - 1) / per;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/amem_start_hold.sv
module amem_start_hold #(
  parameter int unsigned HOLD_CYC = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_good,
  output logic hold_done
);
  localparam int unsigned HW = (HOLD_CYC < 2) ? 1 : $clog2(HOLD_CYC + 1);
  localparam logic [HW-1:0] HOLD_END = HW'(HOLD_CYC);

  logic [HW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!pwr_good)
      cnt_d = '0;
    else if (cnt_q != HOLD_END)
      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign hold_done = pwr_good && (cnt_q == HOLD_END);
endmodule

// File: rtl/amem_seq.sv
module amem_seq
  import amem_pkg::*;
#(
  parameter int unsigned WP_CYC = 1,
  parameter int unsigned WR_CYC = 1,
  parameter int unsigned RW_CYC = 1,
  parameter int unsigned GP_CYC = 1,
  parameter int unsigned WT_W   = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pwr_good,
  input  logic        hold_done,
  input  logic        req_valid,
  input  logic        req_write,
  output logic        req_ready,
  output logic        accept,
  output logic        capture,
  output amem_state_e st_next
);
  localparam logic [WT_W-1:0] WP_LD = WT_W'(WP_CYC - 1);
  localparam logic [WT_W-1:0] WR_LD = WT_W'(WR_CYC - 1);
  localparam logic [WT_W-1:0] RW_LD = WT_W'(RW_CYC - 1);
  localparam logic [WT_W-1:0] GP_LD = WT_W'(GP_CYC - 1);

  amem_state_e     st_q, st_d;
  logic [WT_W-1:0] wt_q, wt_d;
  logic            wt_zero;

  assign wt_zero   = (wt_q == '0);
  assign req_ready = (st_q == ST_IDLE) && pwr_good;

  always_comb begin
    st_d    = st_q;
    wt_d    = wt_q;
    accept  = 1'b0;
    capture = 1'b0;
    if (!pwr_good) begin
      st_d = ST_HOLD;
      wt_d = '0;
    end else begin
      case (st_q)
        ST_HOLD: if (hold_done) st_d = ST_IDLE;
        ST_IDLE: begin
          if (req_valid) begin
            accept = 1'b1;
            if (req_write) begin
              st_d = ST_WPULSE;
              wt_d = WP_LD;
            end else begin
              st_d = ST_RADDR;
              wt_d = '0;
            end
          end
        end
        ST_RADDR: begin
          st_d = ST_RWAIT;
          wt_d = RW_LD;
        end
        ST_RWAIT: begin
          if (wt_zero) begin
            capture = 1'b1;
            st_d    = ST_RGAP;
            wt_d    = GP_LD;
          end else begin
            wt_d = wt_q - 1'b1;
          end
        end
        ST_RGAP: begin
          if (wt_zero) st_d = ST_IDLE;
          else         wt_d = wt_q - 1'b1;
        end
        ST_WPULSE: begin
          if (wt_zero) begin
            st_d = ST_WREC;
            wt_d = WR_LD;
          end else begin
            wt_d = wt_q - 1'b1;
          end
        end
        ST_WREC: begin
          if (wt_zero) st_d = ST_IDLE;
          else         wt_d = wt_q - 1'b1;
        end
        default: st_d = ST_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_HOLD;
      wt_q <= '0;
    end else begin
      st_q <= st_d;
      wt_q <= wt_d;
    end
  end

  assign st_next = st_d;
endmodule

// File: rtl/amem_pin_reg.sv
module amem_pin_reg
  import amem_pkg::*;
#(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  amem_state_e       st_next,
  input  logic              accept,
  input  logic              capture,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);
  logic ce_d, we_d, oe_d, dq_oe_d;

  // strobe levels follow the state being entered, so pins and state move together
  always_comb begin
    ce_d    = !((st_next == ST_RADDR) || (st_next == ST_RWAIT) || (st_next == ST_WPULSE));
    we_d    = !(st_next == ST_WPULSE);
    oe_d    = !(st_next == ST_RWAIT);
    dq_oe_d = (st_next == ST_WPULSE) || (st_next == ST_WREC);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ce_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
      rsp_valid <= 1'b0;
    end else begin
      mem_ce_n  <= ce_d;
      mem_we_n  <= we_d;
      mem_oe_n  <= oe_d;
      mem_dq_oe <= dq_oe_d;
      rsp_valid <= capture;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr   <= '0;
      mem_dq_out <= '0;
      rsp_rdata  <= '0;
    end else begin
      if (accept)             mem_addr   <= req_addr;
      if (accept && req_write) mem_dq_out <= req_wdata;
      if (capture)            rsp_rdata  <= mem_dq_in;
    end
  end
endmodule

// File: rtl/amem_ctrl.sv
module amem_ctrl
  import amem_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS = 20,
  parameter int unsigned ADDR_W        = 17,
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned STARTUP_NS    = 2_000_000,
  parameter int unsigned T_CYCLE_NS    = 35,
  parameter int unsigned T_ADDR_ACC_NS = 35,
  parameter int unsigned T_OE_ACC_NS   = 15,
  parameter int unsigned T_WPULSE_NS   = 15,
  parameter int unsigned T_ADDR_WE_NS  = 18,
  parameter int unsigned T_DSETUP_NS   = 10,
  parameter int unsigned T_WREC_NS     = 12,
  parameter int unsigned T_HIGH_NS     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_good,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n
);
  localparam int unsigned RC_CYC   = ns_to_cyc(T_CYCLE_NS, CLK_PERIOD_NS);
  localparam int unsigned AA_CYC   = ns_to_cyc(T_ADDR_ACC_NS, CLK_PERIOD_NS);
  localparam int unsigned OE_CYC   = ns_to_cyc(T_OE_ACC_NS, CLK_PERIOD_NS);
  localparam int unsigned HI_CYC   = ns_to_cyc(T_HIGH_NS, CLK_PERIOD_NS);
  localparam int unsigned HOLD_CYC = ns_to_cyc(STARTUP_NS, CLK_PERIOD_NS);
  // output enable is high during writes, so the address-to-end limit for that case applies
  localparam int unsigned WP_CYC   = ns_to_cyc(umax(umax(T_WPULSE_NS, T_ADDR_WE_NS), T_DSETUP_NS),
                                               CLK_PERIOD_NS);
  localparam int unsigned WR_CYC   = umax(umax(ns_to_cyc(T_WREC_NS, CLK_PERIOD_NS), HI_CYC),
                                          (RC_CYC > WP_CYC) ? RC_CYC - WP_CYC : 1);
  // one cycle of address-only setup precedes the output-enable phase
  localparam int unsigned RW_CYC   = umax(umax((AA_CYC > 1) ? AA_CYC - 1 : 1,
                                               (RC_CYC > 1) ? RC_CYC - 1 : 1), OE_CYC);
  localparam int unsigned GP_CYC   = HI_CYC;
  localparam int unsigned CNT_MAX  = umax(umax(WP_CYC, WR_CYC), umax(RW_CYC, GP_CYC));
  localparam int unsigned WT_W     = (CNT_MAX < 2) ? 1 : $clog2(CNT_MAX);

  logic [1:0]  rst_sync_q;
  logic        rst_int_n;
  logic        hold_done;
  logic        accept;
  logic        capture;
  amem_state_e st_next;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  amem_start_hold #(
    .HOLD_CYC (HOLD_CYC)
  ) u_hold (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .pwr_good  (pwr_good),
    .hold_done (hold_done)
  );

  amem_seq #(
    .WP_CYC (WP_CYC),
    .WR_CYC (WR_CYC),
    .RW_CYC (RW_CYC),
    .GP_CYC (GP_CYC),
    .WT_W   (WT_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .pwr_good  (pwr_good),
    .hold_done (hold_done),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_ready (req_ready),
    .accept    (accept),
    .capture   (capture),
    .st_next   (st_next)
  );

  amem_pin_reg #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_pins (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .st_next    (st_next),
    .accept     (accept),
    .capture    (capture),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .mem_dq_in  (mem_dq_in),
    .mem_addr   (mem_addr),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe),
    .mem_ce_n   (mem_ce_n),
    .mem_we_n   (mem_we_n),
    .mem_oe_n   (mem_oe_n),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata)
  );
endmodule

// File: rtl/amem_ctrl_chk.sv
module amem_ctrl_chk #(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned WP_CYC = 1,
  parameter int unsigned GP_CYC = 1,
  parameter int unsigned RC_CYC = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pwr_good,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_dq_out,
  input logic              mem_dq_oe,
  input logic              mem_ce_n,
  input logic              mem_we_n,
  input logic              mem_oe_n
);
  localparam int unsigned SAT = (WP_CYC > RC_CYC) ? WP_CYC + 1 : RC_CYC + 1;
  localparam int unsigned CW  = $clog2(SAT + 1);
  localparam logic [CW-1:0] SAT_V = CW'(SAT);

  logic [CW-1:0] we_lo_cnt, ce_hi_cnt, ce_per_cnt;
  logic          ce_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_lo_cnt  <= '0;
      ce_hi_cnt  <= SAT_V;
      ce_per_cnt <= SAT_V;
      ce_d       <= 1'b1;
    end else begin
      ce_d <= mem_ce_n;
      if (mem_we_n)               we_lo_cnt <= '0;
      else if (we_lo_cnt != SAT_V) we_lo_cnt <= we_lo_cnt + 1'b1;
      if (!mem_ce_n)              ce_hi_cnt <= '0;
      else if (ce_hi_cnt != SAT_V) ce_hi_cnt <= ce_hi_cnt + 1'b1;
      if (ce_d && !mem_ce_n)       ce_per_cnt <= CW'(1);
      else if (ce_per_cnt != SAT_V) ce_per_cnt <= ce_per_cnt + 1'b1;
    end
  end

  assert_we_in_ce_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_ce_n);
  assert_wp_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mem_we_n) && $past(pwr_good)) |-> (we_lo_cnt == CW'(WP_CYC)));
  assert_rec_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> ($stable(mem_addr) && $stable(mem_dq_out)));
  assert_oe_hi_wr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n);
  assert_no_fight_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);
  assert_bus_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_oe_n) |-> (!mem_dq_oe && !$past(mem_dq_oe)));
  assert_ce_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_ce_n) |-> (ce_hi_cnt >= CW'(GP_CYC)));
  assert_ce_period_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_ce_n) |-> (ce_per_cnt >= CW'(RC_CYC)));
  assert_ready_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n && pwr_good));
  assert_brownout_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |=> (mem_ce_n && mem_we_n && mem_oe_n && !req_ready && !rsp_valid));
  assert_addr_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));
endmodule

bind amem_ctrl amem_ctrl_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .WP_CYC (WP_CYC),
  .GP_CYC (GP_CYC),
  .RC_CYC (RC_CYC)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pwr_good   (pwr_good),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .mem_addr   (mem_addr),
  .mem_dq_out (mem_dq_out),
  .mem_dq_oe  (mem_dq_oe),
  .mem_ce_n   (mem_ce_n),
  .mem_we_n   (mem_we_n),
  .mem_oe_n   (mem_oe_n)
);

// File: tb/sim_amem_ctrl.sv
`timescale 1ns/1ps
module sim_amem_ctrl;
  localparam int PER     = 20;
  localparam int STARTUP = 2000;

  function automatic int bcyc(input int ns);
    int c;
    c = (ns + PER - 1) / PER;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int bmax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int E_HOLD = bcyc(STARTUP);
  localparam int E_RC   = bcyc(35);
  localparam int E_WP   = bcyc(18);
  localparam int E_WR   = bmax(bmax(bcyc(12), bcyc(2)), bmax(E_RC - E_WP, 1));
  localparam int E_RW   = bmax(bmax(E_RC - 1, 1), bcyc(15));
  localparam int E_GP   = bcyc(2);

  logic        clk = 1'b0;
  logic        rst_n, pwr_good, req_valid, req_write;
  logic [16:0] req_addr;
  logic [7:0]  req_wdata;
  logic        req_ready, rsp_valid, mem_dq_oe, mem_ce_n, mem_we_n, mem_oe_n;
  logic [7:0]  rsp_rdata, mem_dq_out, mem_dq_in;
  logic [16:0] mem_addr;
  logic [7:0]  mem [256];

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  amem_ctrl #(.CLK_PERIOD_NS(PER), .STARTUP_NS(STARTUP)) u0 (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n)
  );

  // behavioural memory: stores while both strobes are low, drives when selected for read
  always @(posedge clk) begin
    if (!mem_ce_n && !mem_we_n) mem[mem_addr[7:0]] <= mem_dq_out;
  end
  assign mem_dq_in = (!mem_ce_n && !mem_oe_n && mem_we_n) ? mem[mem_addr[7:0]] : 8'h00;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic count_hold(input string req);
    int k = 0;
    pwr_good = 1'b1;
    while (!req_ready && k < E_HOLD + 20) begin
      @(negedge clk);
      k++;
      if (!req_ready) chk(mem_ce_n && mem_we_n && mem_oe_n, req, {mem_ce_n, mem_we_n, mem_oe_n}, 7);
    end
    req_valid = 1'b0;
    chk(k == E_HOLD + 1, req, k, E_HOLD + 1);
  endtask

  task automatic accept_req(input bit wr, input logic [16:0] a, input logic [7:0] d);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    req_addr  = ~a;       // R11: a busy controller must not pick this up
    req_wdata = ~d;
  endtask

  task automatic do_write(input logic [16:0] a, input logic [7:0] d);
    int n = 0;
    int m = 0;
    accept_req(1'b1, a, d);
    chk(!mem_ce_n && !mem_we_n, "R3 strobes", {mem_ce_n, mem_we_n}, 0);
    chk(mem_addr == a && mem_dq_out == d, "R3 addr/data", {mem_addr, mem_dq_out}, {a, d});
    chk(mem_oe_n && mem_dq_oe, "R5 oe/drive", {mem_oe_n, mem_dq_oe}, 3);
    chk(!req_ready, "R9 busy", req_ready, 0);
    while (!mem_we_n && n < 50) begin
      n++;
      @(negedge clk);
    end
    chk(n == E_WP, "R3 pulse", n, E_WP);
    chk(mem_ce_n && mem_addr == a && mem_dq_out == d, "R4 hold",
        {mem_ce_n, mem_addr, mem_dq_out}, {1'b1, a, d});
    chk(mem_oe_n, "R5 oe", mem_oe_n, 1);
    while (!req_ready && m < 50) begin
      m++;
      chk(mem_addr == a, "R11 addr", mem_addr, a);
      @(negedge clk);
    end
    chk(m == E_WR, "R4 recovery", m, E_WR);
  endtask

  task automatic do_read(input logic [16:0] a, input logic [7:0] e);
    int n = 0;
    int g = 0;
    accept_req(1'b0, a, 8'h00);
    chk(!mem_ce_n && mem_oe_n && !mem_dq_oe, "R6 setup",
        {mem_ce_n, mem_oe_n, mem_dq_oe}, 2);
    chk(mem_addr == a, "R11 addr", mem_addr, a);
    @(negedge clk);
    while (!mem_oe_n && n < 50) begin
      n++;
      chk(!mem_dq_oe && mem_addr == a, "R6 bus", {mem_dq_oe, mem_addr}, {1'b0, a});
      @(negedge clk);
    end
    chk(n == E_RW, "R6 oe low", n, E_RW);
    chk(rsp_valid && rsp_rdata == e, "R7 data", {rsp_valid, rsp_rdata}, {1'b1, e});
    chk(rsp_rdata == e, "R12 roundtrip", rsp_rdata, e);
    chk(mem_ce_n && !req_ready, "R8 gap", {mem_ce_n, req_ready}, 2);
    while (!req_ready && g < 50) begin
      g++;
      @(negedge clk);
    end
    chk(g == E_GP, "R8 gap len", g, E_GP);
    chk(!rsp_valid && rsp_rdata == e, "R7 pulse", {rsp_valid, rsp_rdata}, {1'b0, e});
  endtask

  // {write, addr, wdata, expected}
  localparam logic [33:0] VEC [10] = '{
    {1'b1, 17'h00000, 8'h5A, 8'h00},
    {1'b1, 17'h1FFFF, 8'hC3, 8'h00},
    {1'b1, 17'h0AB12, 8'h81, 8'h00},
    {1'b0, 17'h00000, 8'h00, 8'h5A},
    {1'b0, 17'h1FFFF, 8'h00, 8'hC3},
    {1'b1, 17'h00000, 8'h00, 8'h00},
    {1'b0, 17'h0AB12, 8'h00, 8'h81},
    {1'b0, 17'h00000, 8'h00, 8'h00},
    {1'b1, 17'h15555, 8'hFF, 8'h00},
    {1'b0, 17'h15555, 8'h00, 8'hFF}
  };

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    rst_n = 1'b0; pwr_good = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    chk(mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && !req_ready && !rsp_valid,
        "R1 in reset", {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, req_ready, rsp_valid}, 6'b111000);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && !req_ready,
        "R1 no power", {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, req_ready}, 5'b11100);

    // R2: a request held through the startup hold must not start anything
    req_valid = 1'b1; req_write = 1'b1; req_addr = 17'h00042; req_wdata = 8'hEE;
    count_hold("R2 startup");
    @(negedge clk);
    chk(mem_ce_n && mem[8'h42] == 8'h00, "R9 ignored", {mem_ce_n, mem[8'h42]}, {1'b1, 8'h00});

    foreach (VEC[i]) begin
      if (VEC[i][33]) do_write(VEC[i][32:16], VEC[i][15:8]);
      else            do_read(VEC[i][32:16], VEC[i][7:0]);
    end

    // R10: supply drop in the middle of a read
    accept_req(1'b0, 17'h1FFFF, 8'h00);
    pwr_good = 1'b0;
    @(negedge clk);
    chk(mem_ce_n && mem_we_n && mem_oe_n && !req_ready, "R10 abort",
        {mem_ce_n, mem_we_n, mem_oe_n, req_ready}, 4'b1110);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(!rsp_valid && mem_ce_n, "R10 no response", {rsp_valid, mem_ce_n}, 1);
    end
    count_hold("R10 restart hold");
    do_read(17'h1FFFF, 8'hC3);
    do_write(17'h000FE, 8'h3C);
    do_read(17'h000FE, 8'h3C);

    finish_run();
  end
endmodule